// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decode

This block is a ten-state counter built from a five-stage twisted-ring (Johnson) shift register, followed by a registered decoder. The decoder drives ten one-hot outputs and a carry flag. The whole block runs on a fast system clock. Two slow control inputs are oversampled and their edges are detected inside the block: a count clock and an active-high inhibit. Advances happen on those edges, and never more than one per system clock.

There are two ways to advance the count:
- a rising edge of the count clock while the inhibit is low;
- a falling edge of the inhibit while the count clock is high.

A high level on the clear input forces the count to state zero and overrides both advance paths. The clear is asserted asynchronously and released synchronously. Feeding decoded output N back into clear turns the block into a divide-by-N counter. The carry flag is high for the first half of the cycle, so its rising edge marks every wrap from nine to zero. That edge can drive the count clock of a following stage.

Top module: `johnson_decade`

## Requirements
- R1: The ring holds one of exactly ten legal patterns: at most one adjacent-bit transition across the five stages. It visits them in a fixed cycle: state k+1 follows state k, and state 0 follows state 9.
- R2: Output `q` is one-hot at all times outside clear. Bit k of `q` is high exactly when the count is k.
- R3: While `inhibit` is low, a rising edge on `cnt_clk` advances the count by one. The new value is visible on `q` no more than four system clocks after the input edge.
- R4: While `inhibit` is high and falls on no edge, `cnt_clk` activity leaves `q` and `carry` unchanged.
- R5: While `cnt_clk` is high, a falling edge on `inhibit` advances the count by one. If both inputs change at once (count clock rising and inhibit falling), the count advances by exactly one.
- R6: A high `clear` forces `q` to 10'b0000000001 (count 0) and `carry` to 1 at once. Count-clock edges while `clear` is high have no effect.
- R7: `carry` is 1 for counts 0 to 4 and 0 for counts 5 to 9.
- R8: With `q[N]` fed back (ORed) into `clear`, the count runs 0, 1, …, N-1, 0 on successive advances. `q[N]` is never seen high at a clock edge. The bench checks this for N = 3 and N = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| clear | input | 1 | Active-high clear to count 0; asynchronous assert, synchronous release |
| cnt_clk | input | 1 | Count clock, oversampled; rising edge advances when not inhibited |
| inhibit | input | 1 | Active-high inhibit, oversampled; falling edge advances while count clock is high |
| q | output | 10 | One-hot decoded count, bit k high in state k |
| carry | output | 1 | High for counts 0 to 4, low for counts 5 to 9 |

## Verification
The hardest situations to reach are the ones where the two advance paths meet. One is both inputs changing in the same system clock; the other is an inhibit falling edge while the count clock is already high. Both take a particular order of input changes that purely directed tests seldom cover. The bench therefore drives long runs of random count-clock and inhibit level pairs from a fixed seed. Many of these pairs move both inputs together. A bench-side model predicts each result from the old and new input levels. Divide-by-N is reached by ORing a chosen decoded output into clear inside the bench. The bench then walks the count through several wraps, so the self-clearing pulse is exercised repeatedly.

// File: rtl/jdc_pkg.sv
`timescale 1ns/1ps
package jdc_pkg;
   // one oversampled control input: settled level and level one clock earlier
   typedef struct packed {
      logic now;
      logic was;
   } samp_t;
endpackage

// File: rtl/jdc_sync.sv
`timescale 1ns/1ps
module jdc_sync
   import jdc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  din,
   output samp_t smp
);
   logic [SYNC_STAGES-1:0] pipe;
   logic                   prev;

   always_ff @(posedge clk) begin
      pipe <= {pipe[SYNC_STAGES-2:0], din};
      prev <= pipe[SYNC_STAGES-1];
   end

   assign smp.now = pipe[SYNC_STAGES-1];
   assign smp.was = prev;
endmodule

// File: rtl/jdc_ring.sv
`timescale 1ns/1ps
module jdc_ring #(
   parameter int STAGES = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   output logic [STAGES-1:0] nxt,
   output logic [STAGES-1:0] state
);
   logic [STAGES-2:0] trans;
   logic              legal;

   assign trans = state[STAGES-2:0] ^ state[STAGES-1:1];
   assign legal = ($countones(trans) <= 1);

   always_comb begin
      nxt = state;
      if (step) begin
         if (legal) nxt = {state[STAGES-2:0], ~state[STAGES-1]};
         else       nxt = '0;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) state <= '0;
      else     state <= nxt;
   end

   // R1
   ring_legal_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(state[STAGES-2:0] ^ state[STAGES-1:1]) <= 1);
endmodule

// File: rtl/jdc_decode.sv
`timescale 1ns/1ps
module jdc_decode #(
   parameter int STAGES = 5
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [STAGES-1:0]   nxt,
   output logic [2*STAGES-1:0] q,
   output logic                carry
);
   localparam int NOUT = 2 * STAGES;
   localparam int IDXW = $clog2(NOUT);

   logic [IDXW-1:0] pop;
   logic [IDXW-1:0] idx;
   logic [NOUT-1:0] q_nxt;

   assign pop = IDXW'($countones(nxt));
   assign idx = nxt[STAGES-1] ? (IDXW'(NOUT) - pop) : pop;

   for (genvar k = 0; k < NOUT; k++) begin : g_dec
      assign q_nxt[k] = (idx == IDXW'(k));
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         q     <= NOUT'(1);
         carry <= 1'b1;
      end else begin
         q     <= q_nxt;
         carry <= ~nxt[STAGES-1];
      end
   end

   // R2
   onehot_out_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(q) == 1);
   // R7
   carry_half_chk: assert property (@(posedge clk) disable iff (rst)
      carry == (|q[STAGES-1:0]));
endmodule

// File: rtl/johnson_decade.sv
`timescale 1ns/1ps
module johnson_decade
   import jdc_pkg::*;
#(
   parameter int STAGES      = 5,
   parameter int SYNC_STAGES = 2,
   localparam int NOUT       = 2 * STAGES
) (
   input  logic            clk,
   input  logic            clear,
   input  logic            cnt_clk,
   input  logic            inhibit,
   output logic [NOUT-1:0] q,
   output logic            carry
);
   if (STAGES < 2) begin : g_bad_stages
      $error("johnson_decade: STAGES must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("johnson_decade: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] rst_pipe;
   logic                   rst_int;
   samp_t                  s_clk;
   samp_t                  s_inh;
   logic                   clk_rise;
   logic                   inh_fall;
   logic                   adv;
   logic [STAGES-1:0]      nxt;
   logic [STAGES-1:0]      state;

   always_ff @(posedge clk or posedge clear) begin
      if (clear) rst_pipe <= '1;
      else       rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b0};
   end
   assign rst_int = rst_pipe[SYNC_STAGES-1];

   jdc_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .din(cnt_clk), .smp(s_clk));
   jdc_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_inh (
      .clk(clk), .din(inhibit), .smp(s_inh));

   assign clk_rise = s_clk.now & ~s_clk.was;
   assign inh_fall = s_inh.was & ~s_inh.now;
   assign adv      = (clk_rise & ~s_inh.now) | (inh_fall & s_clk.now);

   jdc_ring #(.STAGES(STAGES)) u_ring (
      .clk(clk), .rst(rst_int), .step(adv), .nxt(nxt), .state(state));

   jdc_decode #(.STAGES(STAGES)) u_dec (
      .clk(clk), .rst(rst_int), .nxt(nxt), .q(q), .carry(carry));

   // R3
   clk_step_chk: assert property (@(posedge clk) disable iff (rst_int)
      (clk_rise && !s_inh.now) |=> q == {$past(q[NOUT-2:0]), $past(q[NOUT-1])});
   // R4
   hold_chk: assert property (@(posedge clk) disable iff (rst_int)
      (s_inh.now && s_inh.was) |=> ($stable(q) && $stable(carry)));
   // R5
   inh_step_chk: assert property (@(posedge clk) disable iff (rst_int)
      (inh_fall && s_clk.now) |=> q == {$past(q[NOUT-2:0]), $past(q[NOUT-1])});
   // R6
   clear_zero_chk: assert property (@(posedge clk)
      rst_int |-> (q == NOUT'(1) && carry));
endmodule

// File: tb/johnson_decade_test.sv
`timescale 1ns/1ps
module johnson_decade_test;
   logic       clk = 1'b0;
   logic       tb_clear = 1'b1;
   logic       cnt_clk = 1'b0;
   logic       inhibit = 1'b0;
   logic [9:0] q;
   logic       carry;
   logic       clear;
   int         divn = 0;
   int         exp_cnt = 0;
   int         n_tests = 0;
   int         n_fail = 0;
   bit         done = 0;

   always #2.5 clk = ~clk;

   assign clear = tb_clear | ((divn != 0) ? q[divn] : 1'b0);

   johnson_decade uut (
      .clk(clk), .clear(clear), .cnt_clk(cnt_clk), .inhibit(inhibit),
      .q(q), .carry(carry));

   function automatic logic [9:0] exp_q(int c);
      return 10'(1) << c;
   endfunction

   function automatic logic exp_carry(int c);
      return (c < 5);
   endfunction

   function automatic bit will_adv(logic oc, logic oi, logic c, logic i);
      return ((c & ~oc & ~i) | (oi & ~i & c)) != 0;
   endfunction

   task automatic check(string req);
      n_tests++;
      if (q !== exp_q(exp_cnt) || carry !== exp_carry(exp_cnt)) begin
         n_fail++;
         $display("FAIL %s: q=%b carry=%b expected q=%b carry=%b", req,
                  q, carry, exp_q(exp_cnt), exp_carry(exp_cnt));
      end
   endtask

   task automatic drive(logic c, logic i, string req);
      @(negedge clk);
      if (tb_clear == 1'b0 && will_adv(cnt_clk, inhibit, c, i)) begin
         exp_cnt = (exp_cnt + 1) % 10;
         if (divn != 0 && exp_cnt == divn) exp_cnt = 0;
      end
      cnt_clk = c;
      inhibit = i;
      repeat (6) @(posedge clk);
      @(negedge clk);
      check(req);
   endtask

   task automatic do_clear(string req);
      @(negedge clk);
      tb_clear = 1'b1;
      exp_cnt  = 0;
      #1;
      check(req);
      repeat (2) @(posedge clk);
      @(negedge clk);
      tb_clear = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(req);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R6 reset state");
      tb_clear = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R6 after release");

      // R1 R2 R3 R7: full cycle and wrap
      for (int k = 0; k < 12; k++) begin
         drive(1'b1, 1'b0, "R3 R1 R2 R7 rise step");
         drive(1'b0, 1'b0, "R3 fall no step");
      end

      // R4: inhibit high holds
      drive(1'b0, 1'b1, "R4 inhibit raise");
      for (int k = 0; k < 3; k++) begin
         drive(1'b1, 1'b1, "R4 hold on rise");
         drive(1'b0, 1'b1, "R4 hold on fall");
      end

      // R5: inhibit falling edge while count clock high
      drive(1'b1, 1'b1, "R5 clk high inhibited");
      drive(1'b1, 1'b0, "R5 inhibit fall step");
      drive(1'b0, 1'b0, "R5 idle");
      drive(1'b0, 1'b1, "R5 inhibit with clk low");
      drive(1'b0, 1'b0, "R5 inhibit fall clk low no step");
      // simultaneous rise and inhibit fall: one step
      drive(1'b0, 1'b1, "R5 setup");
      drive(1'b1, 1'b0, "R5 simultaneous single step");
      drive(1'b0, 1'b0, "R5 idle");

      // R6: clear mid count and clear overrides counting
      do_clear("R6 clear mid count");
      @(negedge clk);
      tb_clear = 1'b1;
      exp_cnt  = 0;
      for (int k = 0; k < 3; k++) begin
         cnt_clk = 1'b1;
         repeat (6) @(posedge clk);
         @(negedge clk);
         check("R6 clock ignored under clear");
         cnt_clk = 1'b0;
         repeat (6) @(posedge clk);
         @(negedge clk);
      end
      tb_clear = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R6 still zero after release");

      // random mix of both paths
      for (int k = 0; k < 400; k++) begin
         logic c, i;
         c = 1'($urandom);
         i = 1'($urandom);
         drive(c, i, "R3 R4 R5 R7 random");
      end
      drive(1'b0, 1'b0, "R3 settle");

      // R8: divide by 3 and divide by 7
      do_clear("R8 prep");
      divn = 3;
      for (int k = 0; k < 8; k++) begin
         drive(1'b1, 1'b0, "R8 div3 step");
         drive(1'b0, 1'b0, "R8 div3 idle");
      end
      divn = 0;
      do_clear("R8 prep");
      divn = 7;
      for (int k = 0; k < 16; k++) begin
         drive(1'b1, 1'b0, "R8 div7 step");
         drive(1'b0, 1'b0, "R8 div7 idle");
      end
      divn = 0;

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule